// File: doc/BRIEF.md
# Vectored Interrupt Latch with Line Remap

This block sits between sixteen level-sensitive legacy device interrupt lines and a processor core that takes vectored interrupts. A fixed, sparse table gives five of the lines an interrupt vector number. The other lines are never looked at. When a mapped line goes from low to high and nothing is held, the block captures that interrupt. It records which line it came from and loads three 64-bit data words. It sets a pending flag, drives the vectored-interrupt trap type and raises a hard-interrupt request to the core.

The holding stage is one entry deep. While it is occupied, any further rising edge is discarded and the held contents do not change. The entry is released only when the line that caused it goes low again. Lines are edge-detected against their value on the previous clock. A line that stays high therefore produces at most one capture, and a discarded edge is not replayed later.

Top module: `vil_top`

## Requirements
- R1: The remap is fixed. Line 7 gives vector 0x22, line 6 gives 0x27, line 1 gives 0x29, line 12 gives 0x2A and line 4 gives 0x2B.
- R2: When the holding stage is empty and a mapped line rises, the next clock edge sets the pending output and the request output and sets the trap type to 0x60.
- R3: On a capture, data word 0 becomes 0x7C0 OR the vector, which is 0x1F in bits 10:6 and the vector in bits 5:0. Data words 1 and 2 become zero.
- R4: While pending, a fall of the originating line clears pending and request at the next edge. The trap type and data word 0 keep their values.
- R5: A rising edge on any mapped line while pending is dropped, and the held data and origin are not overwritten.
- R6: Lines 0, 2, 3, 5, 8 to 11 and 13 to 15 have no effect on any output.
- R7: If several mapped lines rise in the same cycle while the stage is empty, the lowest-numbered one is captured.
- R8: Captures are edge-triggered. A mapped line that is still high when the stage empties is not captured until it falls and rises again.
- R9: While pending, a fall of a line other than the originating one does not clear the entry.
- R10: After synchronous reset, pending, request, trap type and all three data words are zero.
- R11: Every output reflects the line values sampled at the preceding rising clock edge, with exactly one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_lines_i | input | 16 | Level-sensitive legacy interrupt lines |
| pending_o | output | 1 | An interrupt is held |
| hard_req_o | output | 1 | Hard-interrupt request to the core |
| trap_type_o | output | 9 | Trap type of the held interrupt (0x60) |
| data0_o | output | 64 | Data word 0: 0x1F in bits 10:6, vector in bits 5:0 |
| data1_o | output | 64 | Data word 1, zero on capture |
| data2_o | output | 64 | Data word 2, zero on capture |

## Verification
The bench targets several corner cases.

- A second raise while the stage is full: a design that overwrote here would show a new data word 0.
- A fall of a non-originating line: a design that released on any fall would drop pending early.
- A fall of the origin in the same cycle that another mapped line rises: the rise must be lost, and a design that accepted it would re-capture at once.
- A line left high across a release: a level-triggered design would re-capture it.
- Simultaneous rises: a wrong priority order would pick the wrong vector.
- A walk over all sixteen lines: this exposes any table entry that is wrong, missing or extra.

// File: rtl/vil_pkg.sv
package vil_pkg;
  localparam int VEC_W   = 6;
  localparam int TAG_W   = 5;
  localparam logic [TAG_W-1:0] VEC_TAG = 5'h1F;

  function automatic logic line_mapped(input int idx);
    case (idx)
      1, 4, 6, 7, 12: line_mapped = 1'b1;
      default:        line_mapped = 1'b0;
    endcase
  endfunction

  function automatic logic [VEC_W-1:0] line_vector(input int idx);
    case (idx)
      1:       line_vector = 6'h29;
      4:       line_vector = 6'h2B;
      6:       line_vector = 6'h27;
      7:       line_vector = 6'h22;
      12:      line_vector = 6'h2A;
      default: line_vector = '0;
    endcase
  endfunction
endpackage

// File: rtl/vil_edge.sv
module vil_edge #(
  parameter int N_LINES = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_LINES-1:0] lines_i,
  output logic [N_LINES-1:0] rise_o,
  output logic [N_LINES-1:0] fall_o
);
  logic [N_LINES-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= lines_i;
  end

  assign rise_o = lines_i & ~prev_q;
  assign fall_o = ~lines_i & prev_q;
endmodule

// File: rtl/vil_remap.sv
module vil_remap #(
  parameter int N_LINES = 16,
  localparam int IDX_W = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [N_LINES-1:0]       rise_i,
  output logic                     hit_o,
  output logic [IDX_W-1:0]         win_idx_o,
  output logic [vil_pkg::VEC_W-1:0] win_vec_o
);
  logic [N_LINES-1:0]         mapped;
  logic [vil_pkg::VEC_W-1:0]  vec_tab [N_LINES];
  logic [N_LINES-1:0]         cand;

  for (genvar g = 0; g < N_LINES; g++) begin : g_tab
    assign mapped[g]  = vil_pkg::line_mapped(g);
    assign vec_tab[g] = vil_pkg::line_vector(g);
  end

  assign cand = rise_i & mapped;

  always_comb begin
    hit_o     = 1'b0;
    win_idx_o = '0;
    win_vec_o = '0;
    for (int i = N_LINES - 1; i >= 0; i--) begin
      if (cand[i]) begin
        hit_o     = 1'b1;
        win_idx_o = IDX_W'(i);
        win_vec_o = vec_tab[i];
      end
    end
  end

  logic [N_LINES-1:0] below_mask;
  assign below_mask = (N_LINES'(1) << win_idx_o) - N_LINES'(1);

  AST_WIN_LOWEST: assert property (@(posedge clk) disable iff (rst)
    hit_o |-> (cand[win_idx_o] && ((cand & below_mask) == '0))); // R7

  AST_NO_UNMAPPED: assert property (@(posedge clk) disable iff (rst)
    ((rise_i & mapped) == '0) |-> !hit_o); // R6
endmodule

// File: rtl/vil_latch.sv
module vil_latch #(
  parameter int N_LINES = 16,
  parameter int DATA_W  = 64,
  parameter int TT_W    = 9,
  parameter logic [TT_W-1:0] TT_VEC = 9'h060,
  localparam int IDX_W = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [N_LINES-1:0]        fall_i,
  input  logic                      hit_i,
  input  logic [IDX_W-1:0]          win_idx_i,
  input  logic [vil_pkg::VEC_W-1:0] win_vec_i,
  output logic                      pend_o,
  output logic                      req_o,
  output logic [TT_W-1:0]           tt_o,
  output logic [DATA_W-1:0]         d0_o,
  output logic [DATA_W-1:0]         d1_o,
  output logic [DATA_W-1:0]         d2_o
);
  localparam int SHIFT = vil_pkg::VEC_W;

  logic              pend_q, req_q;
  logic [IDX_W-1:0]  src_q;
  logic [TT_W-1:0]   tt_q;
  logic [DATA_W-1:0] d0_q, d1_q, d2_q;
  logic [DATA_W-1:0] d0_new;

  assign d0_new = (DATA_W'(vil_pkg::VEC_TAG) << SHIFT) | DATA_W'(win_vec_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      req_q  <= 1'b0;
      src_q  <= '0;
      tt_q   <= '0;
      d0_q   <= '0;
      d1_q   <= '0;
      d2_q   <= '0;
    end else if (pend_q) begin
      if (fall_i[src_q]) begin
        pend_q <= 1'b0;
        req_q  <= 1'b0;
      end
    end else if (hit_i) begin
      pend_q <= 1'b1;
      req_q  <= 1'b1;
      src_q  <= win_idx_i;
      tt_q   <= TT_VEC;
      d0_q   <= d0_new;
      d1_q   <= '0;
      d2_q   <= '0;
    end
  end

  assign pend_o = pend_q;
  assign req_o  = req_q;
  assign tt_o   = tt_q;
  assign d0_o   = d0_q;
  assign d1_o   = d1_q;
  assign d2_o   = d2_q;

  AST_TT_ON_RAISE: assert property (@(posedge clk) disable iff (rst)
    $rose(pend_q) |-> (tt_q == TT_VEC)); // R2

  AST_HELD_STABLE: assert property (@(posedge clk) disable iff (rst)
    (pend_q && $past(pend_q)) |-> ($stable(d0_q) && $stable(src_q))); // R5

  AST_ZERO_WORDS: assert property (@(posedge clk) disable iff (rst)
    (d1_q == '0) && (d2_q == '0)); // R3

  AST_CLEAR_ON_SRC_FALL: assert property (@(posedge clk) disable iff (rst)
    (pend_q && fall_i[src_q]) |=> !pend_q); // R4

  AST_KEEP_ON_OTHER: assert property (@(posedge clk) disable iff (rst)
    (pend_q && !fall_i[src_q]) |=> pend_q); // R9

  AST_REQ_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    req_q == pend_q); // R4
endmodule

// File: rtl/vil_top.sv
module vil_top #(
  parameter int N_LINES = 16,
  parameter int DATA_W  = 64,
  parameter int TT_W    = 9,
  parameter logic [TT_W-1:0] TT_VEC = 9'h060
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_LINES-1:0] irq_lines_i,
  output logic               pending_o,
  output logic               hard_req_o,
  output logic [TT_W-1:0]    trap_type_o,
  output logic [DATA_W-1:0]  data0_o,
  output logic [DATA_W-1:0]  data1_o,
  output logic [DATA_W-1:0]  data2_o
);
  localparam int IDX_W = (N_LINES > 1) ? $clog2(N_LINES) : 1;

  logic [N_LINES-1:0]        rise, fall;
  logic                      hit;
  logic [IDX_W-1:0]          win_idx;
  logic [vil_pkg::VEC_W-1:0] win_vec;

  vil_edge #(.N_LINES(N_LINES)) u_edge (
    .clk     (clk),
    .rst     (rst),
    .lines_i (irq_lines_i),
    .rise_o  (rise),
    .fall_o  (fall)
  );

  vil_remap #(.N_LINES(N_LINES)) u_remap (
    .clk       (clk),
    .rst       (rst),
    .rise_i    (rise),
    .hit_o     (hit),
    .win_idx_o (win_idx),
    .win_vec_o (win_vec)
  );

  vil_latch #(
    .N_LINES (N_LINES),
    .DATA_W  (DATA_W),
    .TT_W    (TT_W),
    .TT_VEC  (TT_VEC)
  ) u_latch (
    .clk       (clk),
    .rst       (rst),
    .fall_i    (fall),
    .hit_i     (hit),
    .win_idx_i (win_idx),
    .win_vec_i (win_vec),
    .pend_o    (pending_o),
    .req_o     (hard_req_o),
    .tt_o      (trap_type_o),
    .d0_o      (data0_o),
    .d1_o      (data1_o),
    .d2_o      (data2_o)
  );
endmodule

// File: tb/vil_top_test.sv
`timescale 1ns/1ps
module vil_top_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] lines = '0;
  logic        pending_o, hard_req_o;
  logic [8:0]  trap_type_o;
  logic [63:0] data0_o, data1_o, data2_o;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 0;
  bit cmp_on = 0;

  // behavioural reference state
  logic [15:0] m_prev;
  bit          m_pend;
  int          m_src;
  logic [63:0] m_d0;
  logic [8:0]  m_tt;

  always #2.5 clk = ~clk;

  vil_top uut (
    .clk(clk), .rst(rst), .irq_lines_i(lines),
    .pending_o(pending_o), .hard_req_o(hard_req_o), .trap_type_o(trap_type_o),
    .data0_o(data0_o), .data1_o(data1_o), .data2_o(data2_o)
  );

  function automatic int vec_of(int line);
    // R1 table
    if (line == 7)  return 'h22;
    if (line == 6)  return 'h27;
    if (line == 1)  return 'h29;
    if (line == 12) return 'h2A;
    if (line == 4)  return 'h2B;
    return -1;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_prev = '0; m_pend = 0; m_src = 0; m_d0 = '0; m_tt = '0;
  endtask

  task automatic model_step(logic [15:0] v);
    if (m_pend) begin
      if (m_prev[m_src] && !v[m_src]) m_pend = 0;
    end else begin
      for (int i = 0; i < 16; i++) begin
        if (v[i] && !m_prev[i] && vec_of(i) >= 0) begin
          m_pend = 1; m_src = i; m_tt = 9'h060;
          m_d0 = 64'h7C0 | 64'(vec_of(i));
          break;
        end
      end
    end
    m_prev = v;
  endtask

  task automatic compare_model();
    if (!cmp_on) return;
    check("R11 pending vs model", {63'd0, pending_o}, {63'd0, m_pend});
    check("R11 request vs model", {63'd0, hard_req_o}, {63'd0, m_pend});
    check("R11 trap type vs model", {55'd0, trap_type_o}, {55'd0, m_tt});
    check("R11 data0 vs model", data0_o, m_d0);
    check("R3 data1 vs model", data1_o, 64'd0);
    check("R3 data2 vs model", data2_o, 64'd0);
  endtask

  // apply new line values at a negedge; the design reacts at the next posedge
  task automatic drive(logic [15:0] v);
    @(negedge clk);
    compare_model();
    lines = v;
    model_step(v);
    @(posedge clk); #1;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !done) begin
      failures++;
      $display("FAIL R11 watchdog expired actual=%0d expected<=50000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    model_reset();
    rst = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    // R10 reset state
    check("R10 pending after reset", {63'd0, pending_o}, 64'd0);
    check("R10 request after reset", {63'd0, hard_req_o}, 64'd0);
    check("R10 trap type after reset", {55'd0, trap_type_o}, 64'd0);
    check("R10 data0 after reset", data0_o, 64'd0);
    check("R10 data1 after reset", data1_o, 64'd0);
    check("R10 data2 after reset", data2_o, 64'd0);
    cmp_on = 1;

    // R2 R3: capture line 4
    drive(16'h0010);
    check("R2 pending on raise", {63'd0, pending_o}, 64'd1);
    check("R2 request on raise", {63'd0, hard_req_o}, 64'd1);
    check("R2 trap type", {55'd0, trap_type_o}, 64'h60);
    check("R3 data0 line4", data0_o, 64'h7EB);
    check("R3 data1 zero", data1_o, 64'd0);

    // R5: raise line 1 while full
    drive(16'h0012);
    check("R5 data0 kept on dropped raise", data0_o, 64'h7EB);
    check("R5 still pending", {63'd0, pending_o}, 64'd1);

    // R9: non-origin line falls
    drive(16'h0010);
    check("R9 pending kept on other fall", {63'd0, pending_o}, 64'd1);

    // R4: origin falls
    drive(16'h0000);
    check("R4 pending cleared", {63'd0, pending_o}, 64'd0);
    check("R4 request cleared", {63'd0, hard_req_o}, 64'd0);
    check("R4 trap type held", {55'd0, trap_type_o}, 64'h60);
    check("R4 data0 held", data0_o, 64'h7EB);

    // R6: unmapped lines
    drive(16'hEF2D);
    check("R6 unmapped rise ignored", {63'd0, pending_o}, 64'd0);
    check("R6 data0 unchanged", data0_o, 64'h7EB);
    drive(16'h0000);
    check("R6 unmapped fall ignored", {63'd0, pending_o}, 64'd0);

    // R7: simultaneous rises of 6, 7, 12
    drive(16'h10C0);
    check("R7 lowest wins data0", data0_o, 64'h7E7);
    // R8: raise 1 while full, then origin 6 falls; 1,7,12 stay high
    drive(16'h10C2);
    drive(16'h1082);
    check("R8 released", {63'd0, pending_o}, 64'd0);
    drive(16'h1082);
    check("R8 held-high line not captured", {63'd0, pending_o}, 64'd0);
    drive(16'h0000);

    // origin fall coinciding with another mapped rise: rise lost
    drive(16'h1000);
    check("R1 line12 vector", data0_o, 64'h7EA);
    drive(16'h0080);
    check("R5 rise during release dropped", {63'd0, pending_o}, 64'd0);
    drive(16'h0080);
    check("R8 line7 not captured later", {63'd0, pending_o}, 64'd0);
    drive(16'h0000);

    // R1 walk all lines
    for (int i = 0; i < 16; i++) begin
      drive(16'(1 << i));
      if (vec_of(i) >= 0) begin
        check("R1 mapped line pending", {63'd0, pending_o}, 64'd1);
        check("R1 mapped line vector", data0_o, 64'h7C0 | 64'(vec_of(i)));
      end else begin
        check("R6 unmapped line idle", {63'd0, pending_o}, 64'd0);
      end
      drive(16'h0000);
    end

    // R11 pattern sweep against the model
    for (int k = 0; k < 200; k++) begin
      drive(16'((k * 16'h9E37 + 16'h1234) ^ (k << 3)));
    end
    drive(16'h0000);
    @(negedge clk);
    compare_model();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule